// File: doc/BRIEF.md
# Descriptor-Ring DMA Channel Status Tracker

This block keeps the status of one bus-master audio DMA channel that walks a ring of buffer descriptors. The descriptor engine, which lives elsewhere, reports the current ring index, the last valid index, and a set of one-cycle strobes: a descriptor was fetched, a buffer's data reached memory, the current buffer is fully processed, and one sample was processed. The block also sees the run bit and interrupt enable from the channel control register and an engine-idle level. From these it maintains a 16-bit status word and a 16-bit count of the samples left in the current buffer, and it drives the channel interrupt.

The status word holds three flags. The halted flag is a level. The index-match flag is a level that is set when the current index equals the last valid index and the buffer at that index has been processed. The completion flag is an event that software clears by writing 1 to it. The completion flag sets at a point in the pipeline that depends on direction: a transmit channel (parameter `TX_DIR=1`) sets it when the last valid descriptor is fetched, and a receive channel sets it when the last buffer's data has been written to memory. Software reads the status and the position through a small read window. A 32-bit read at the position offset also returns the two byte-wide neighbour registers above it.

Top module: `dma_ring_status`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the status word reads 0001h, the position reads 0000h and irq is 0.
- R2: The halted flag (status bit 0) is 1 one cycle after a cycle with run=0 and eng_idle=1, or a cycle in which the index-match flag is set. It is 0 one cycle after a cycle with run=1 and no index match, and also when run=0 while eng_idle=0.
- R3: The completion flag (status bit 2) sets one cycle after a qualifying strobe while cur_idx equals last_idx. With TX_DIR=1 the qualifying strobe is buf_fetched. With TX_DIR=0 it is buf_written. The other strobe does not set the flag.
- R4: A write to offset 06h with wr_data bit 2 = 1 clears the completion flag one cycle later. Writing 0 to bit 2 leaves the flag unchanged. If a set and a clear occur in the same cycle, the flag stays set.
- R5: irq is 1 exactly while status bit 2 is 1 and irq_en is 1. Clearing bit 2 drops irq.
- R6: The index-match flag (status bit 1) is 1 one cycle after buf_done arrives while cur_idx equals last_idx, and it stays 1 while the indices remain equal. It is 0 one cycle after the indices differ, for example after last_idx changes.
- R7: Status bits 15 to 3 always read 0. Software writes have no effect on status bits 0 and 1.
- R8: The position loads buf_len one cycle after buf_fetched. Each sample_tick decrements it by one, and it holds at 0 instead of wrapping. When a load and a tick occur in the same cycle, the load wins.
- R9: A read at offset 06h returns the status word in bits 15:0, with zeros above. A 16-bit read (rd_wide=0) at offset 08h returns the position in bits 15:0, with zeros above. A 32-bit read (rd_wide=1) at offset 08h returns {nbr_hi, nbr_lo, position}. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_idx | input | IDX_W | Ring index of the current descriptor |
| last_idx | input | IDX_W | Last valid ring index |
| run | input | 1 | Run bit from the control register |
| irq_en | input | 1 | Completion interrupt enable |
| eng_idle | input | 1 | DMA engines idle |
| buf_fetched | input | 1 | Strobe: descriptor at cur_idx fetched |
| buf_len | input | POS_W | Sample length of the fetched descriptor |
| buf_written | input | 1 | Strobe: current buffer's data written to memory |
| buf_done | input | 1 | Strobe: buffer at cur_idx fully processed |
| sample_tick | input | 1 | Strobe: one sample processed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte offset of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Byte offset of the read |
| rd_wide | input | 1 | 1 for a 32-bit read, 0 for a 16-bit read |
| nbr_lo | input | 8 | Byte register at offset 0Ah |
| nbr_hi | input | 8 | Byte register at offset 0Bh |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Channel interrupt |

## Verification
The bench builds two copies that share every input. `uut` uses TX_DIR=1 and `uut_rx` uses TX_DIR=0, both with IDX_W=3. With this setup, one strobe sequence shows that the completion flag responds to the fetch strobe in one copy and to the memory-write strobe in the other, and that each copy ignores the opposite strobe. The narrow index keeps the index-equality cases easy to set up. The bench uses short buffer lengths, so the position reaches its floor at zero within a few ticks.

// File: rtl/drs_pkg.sv
// Shared constants for the DMA ring status tracker: register offsets and
// status bit positions. Assumes a 16-byte channel register window.
package drs_pkg;
    localparam int OFF_W       = 4;
    localparam int STAT_W      = 16;
    localparam int BUS_W       = 32;
    localparam logic [OFF_W-1:0] STATUS_OFF = 4'h6;
    localparam logic [OFF_W-1:0] POS_OFF    = 4'h8;
    localparam int BIT_HALT    = 0;
    localparam int BIT_MATCH   = 1;
    localparam int BIT_DONE    = 2;
endpackage

// File: rtl/drs_flags.sv
// Status flag logic: halted level, index-match level and completion event.
// Assumes single-cycle strobes from the descriptor engine and a clear
// request already decoded from the register write port.
module drs_flags #(
    parameter int IDX_W  = 5,
    parameter bit TX_DIR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             run,
    input  logic             eng_idle,
    input  logic             buf_fetched,
    input  logic             buf_written,
    input  logic             buf_done,
    input  logic             clr_done,
    output logic             halted,
    output logic             match,
    output logic             done_ev
);
    logic idx_eq;
    logic set_done;
    logic match_d;

    assign idx_eq = (cur_idx == last_idx);

    // Direction picks which pipeline point reports last-buffer completion
    generate
        if (TX_DIR) begin : g_tx
            assign set_done = idx_eq & buf_fetched;
        end else begin : g_rx
            assign set_done = idx_eq & buf_written;
        end
    endgenerate

    logic unused_strobe;
    assign unused_strobe = TX_DIR ? buf_written : buf_fetched;

    // Match level: held while indices agree, armed by a processed buffer
    assign match_d = idx_eq & (match | buf_done);

    // Register the match and halted levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match  <= 1'b0;
            halted <= 1'b1;
        end else begin
            match  <= match_d;
            halted <= (~run & eng_idle) | match_d;
        end
    end

    // Completion event: hardware set has priority over software clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_ev <= 1'b0;
        else if (set_done)
            done_ev <= 1'b1;
        else if (clr_done)
            done_ev <= 1'b0;
    end

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> done_ev);
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !set_done) |=> !done_ev);
    a_r6_match_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_idx != last_idx) |=> !match);
    a_r2_halt_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && eng_idle) |=> halted);
    a_r2_run_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !idx_eq) |=> !halted);
endmodule

// File: rtl/drs_position.sv
// Position-in-current-buffer counter: loads the descriptor length on
// fetch, counts down per processed sample and holds at zero.
module drs_position #(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [POS_W-1:0] load_val,
    input  logic             tick,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] ZERO = '0;
    localparam logic [POS_W-1:0] ONE  = {{(POS_W-1){1'b0}}, 1'b1};

    // Load beats tick; tick stops at zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos <= ZERO;
        else if (load)
            pos <= load_val;
        else if (tick && pos != ZERO)
            pos <= pos - ONE;
    end

    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> pos == $past(load_val));
    a_r8_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && pos == ZERO) |=> pos == ZERO);
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && pos != ZERO) |=> pos == $past(pos) - ONE);
endmodule

// File: rtl/drs_readwin.sv
// Read window decode: status at its offset, the position as a 16-bit or
// a 32-bit read with the two neighbour bytes. Purely combinational.
module drs_readwin #(
    parameter int POS_W = 16
) (
    input  logic [drs_pkg::OFF_W-1:0]  rd_addr,
    input  logic                       rd_wide,
    input  logic [drs_pkg::STAT_W-1:0] status,
    input  logic [POS_W-1:0]           pos,
    input  logic [7:0]                 nbr_lo,
    input  logic [7:0]                 nbr_hi,
    output logic [drs_pkg::BUS_W-1:0]  rd_data
);
    import drs_pkg::*;
    localparam int POS_PAD = 16 - POS_W;

    logic [15:0] pos_ext;
    assign pos_ext = {{POS_PAD{1'b0}}, pos};

    // Select the returned word by offset and access width
    always_comb begin
        rd_data = '0;
        if (rd_addr == STATUS_OFF)
            rd_data = {16'h0000, status};
        else if (rd_addr == POS_OFF)
            rd_data = rd_wide ? {nbr_hi, nbr_lo, pos_ext} : {16'h0000, pos_ext};
    end
endmodule

// File: rtl/dma_ring_status.sv
// Top of the DMA ring status tracker. Decodes the write port into the
// completion clear, assembles the 16-bit status word and drives irq.
// Assumes strobes are single-cycle and the position fits in 16 bits.
module dma_ring_status #(
    parameter int IDX_W  = 5,
    parameter int POS_W  = 16,
    parameter bit TX_DIR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             run,
    input  logic             irq_en,
    input  logic             eng_idle,
    input  logic             buf_fetched,
    input  logic [POS_W-1:0] buf_len,
    input  logic             buf_written,
    input  logic             buf_done,
    input  logic             sample_tick,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [15:0]      wr_data,
    input  logic [3:0]       rd_addr,
    input  logic             rd_wide,
    input  logic [7:0]       nbr_lo,
    input  logic [7:0]       nbr_hi,
    output logic [31:0]      rd_data,
    output logic             irq
);
    import drs_pkg::*;

    logic clr_done;
    logic halted, match, done_ev;
    logic [STAT_W-1:0] status;
    logic [POS_W-1:0]  pos;

    // Only a 1 in the completion bit at the status offset clears it
    assign clr_done = wr_en && (wr_addr == STATUS_OFF) && wr_data[BIT_DONE];

    logic unused_wr;
    assign unused_wr = ^{wr_data[15:3], wr_data[1:0]};

    // Assemble status; unimplemented bits are constant zero
    always_comb begin
        status            = '0;
        status[BIT_HALT]  = halted;
        status[BIT_MATCH] = match;
        status[BIT_DONE]  = done_ev;
    end

    assign irq = done_ev & irq_en;

    drs_flags #(.IDX_W(IDX_W), .TX_DIR(TX_DIR)) u_flags (
        .clk(clk), .rst_n(rst_n), .cur_idx(cur_idx), .last_idx(last_idx),
        .run(run), .eng_idle(eng_idle), .buf_fetched(buf_fetched),
        .buf_written(buf_written), .buf_done(buf_done), .clr_done(clr_done),
        .halted(halted), .match(match), .done_ev(done_ev)
    );

    drs_position #(.POS_W(POS_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .load(buf_fetched), .load_val(buf_len),
        .tick(sample_tick), .pos(pos)
    );

    drs_readwin #(.POS_W(POS_W)) u_rd (
        .rd_addr(rd_addr), .rd_wide(rd_wide), .status(status), .pos(pos),
        .nbr_lo(nbr_lo), .nbr_hi(nbr_hi), .rd_data(rd_data)
    );

    a_r5_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_ev) |-> !irq);
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == STATUS_OFF) |-> rd_data[31:3] == '0);
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (halted && !match && !done_ev && pos == '0));
endmodule

// File: tb/dma_ring_status_test.sv
module dma_ring_status_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cur_idx = 3'd2, last_idx = 3'd3;
    logic run = 1'b0, irq_en = 1'b0, eng_idle = 1'b1;
    logic buf_fetched = 1'b0, buf_written = 1'b0, buf_done = 1'b0, sample_tick = 1'b0;
    logic [15:0] buf_len = 16'd0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = 4'h0, rd_addr = 4'h6;
    logic [15:0] wr_data = 16'h0;
    logic rd_wide = 1'b0;
    logic [7:0] nbr_lo = 8'h5A, nbr_hi = 8'hC3;
    logic [31:0] rd_tx, rd_rx;
    logic irq_tx, irq_rx;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_ring_status #(.IDX_W(3), .POS_W(16), .TX_DIR(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cur_idx(cur_idx), .last_idx(last_idx), .run(run),
        .irq_en(irq_en), .eng_idle(eng_idle), .buf_fetched(buf_fetched), .buf_len(buf_len),
        .buf_written(buf_written), .buf_done(buf_done), .sample_tick(sample_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_wide(rd_wide), .nbr_lo(nbr_lo), .nbr_hi(nbr_hi), .rd_data(rd_tx), .irq(irq_tx));

    dma_ring_status #(.IDX_W(3), .POS_W(16), .TX_DIR(1'b0)) uut_rx (
        .clk(clk), .rst_n(rst_n), .cur_idx(cur_idx), .last_idx(last_idx), .run(run),
        .irq_en(irq_en), .eng_idle(eng_idle), .buf_fetched(buf_fetched), .buf_len(buf_len),
        .buf_written(buf_written), .buf_done(buf_done), .sample_tick(sample_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_wide(rd_wide), .nbr_lo(nbr_lo), .nbr_hi(nbr_hi), .rd_data(rd_rx), .irq(irq_rx));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, input logic w);
        rd_addr = a; rd_wide = w; #1;
    endtask

    task automatic wr_status(input logic [15:0] d);
        wr_en = 1'b1; wr_addr = 4'h6; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rd(4'h6, 1'b0);
        chk("R1 status", rd_tx, 32'h0001);
        rd(4'h8, 1'b0);
        chk("R1 position", rd_tx, 32'h0000);
        chk("R1 irq", {31'b0, irq_tx}, 32'h0);
    endtask

    task automatic t_tx_completion();
        run = 1'b1; eng_idle = 1'b0; cur_idx = 3'd2; last_idx = 3'd3;
        tick(); rd(4'h6, 1'b0);
        chk("R2 running", rd_tx, 32'h0000);
        buf_fetched = 1'b1; buf_len = 16'd9;
        tick(); buf_fetched = 1'b0; rd(4'h6, 1'b0);
        chk("R3 fetch not last", rd_tx, 32'h0000);
        cur_idx = 3'd3; buf_fetched = 1'b1;
        tick(); buf_fetched = 1'b0; rd(4'h6, 1'b0);
        chk("R3 tx sets on fetch", rd_tx, 32'h0004);
        chk("R3 rx ignores fetch", rd_rx, 32'h0000);
        chk("R5 irq off when disabled", {31'b0, irq_tx}, 32'h0);
        irq_en = 1'b1; #1;
        chk("R5 irq on", {31'b0, irq_tx}, 32'h1);
    endtask

    task automatic t_clear();
        wr_status(16'hFFFB); rd(4'h6, 1'b0);
        chk("R4 write 0 keeps", rd_tx, 32'h0004);
        wr_status(16'h0004); rd(4'h6, 1'b0);
        chk("R4 clear", rd_tx, 32'h0000);
        chk("R5 irq drops", {31'b0, irq_tx}, 32'h0);
    endtask

    task automatic t_set_wins();
        buf_fetched = 1'b1; buf_len = 16'd4;
        wr_en = 1'b1; wr_addr = 4'h6; wr_data = 16'h0004;
        tick(); buf_fetched = 1'b0; wr_en = 1'b0; rd(4'h6, 1'b0);
        chk("R4 set wins", rd_tx, 32'h0004);
        wr_status(16'h0004); rd(4'h6, 1'b0);
        chk("R4 clear after", rd_tx, 32'h0000);
    endtask

    task automatic t_position();
        cur_idx = 3'd1; buf_fetched = 1'b1; buf_len = 16'd3;
        tick(); buf_fetched = 1'b0; rd(4'h8, 1'b0);
        chk("R8 load", rd_tx, 32'h0003);
        sample_tick = 1'b1;
        tick(); rd(4'h8, 1'b0);
        chk("R8 decrement", rd_tx, 32'h0002);
        tick(); tick(); tick(); sample_tick = 1'b0; rd(4'h8, 1'b0);
        chk("R8 floor at zero", rd_tx, 32'h0000);
        buf_fetched = 1'b1; buf_len = 16'd7; sample_tick = 1'b1;
        tick(); buf_fetched = 1'b0; sample_tick = 1'b0; rd(4'h8, 1'b0);
        chk("R8 load beats tick", rd_tx, 32'h0007);
    endtask

    task automatic t_readwin();
        rd(4'h8, 1'b1);
        chk("R9 wide read", rd_tx, 32'hC35A0007);
        rd(4'h8, 1'b0);
        chk("R9 narrow read", rd_tx, 32'h00000007);
        rd(4'h4, 1'b1);
        chk("R9 other offset", rd_tx, 32'h0);
    endtask

    task automatic t_match_halt();
        cur_idx = 3'd3; last_idx = 3'd3;
        tick(); rd(4'h6, 1'b0);
        chk("R6 no match before done", rd_tx, 32'h0000);
        buf_done = 1'b1;
        tick(); buf_done = 1'b0; rd(4'h6, 1'b0);
        chk("R6 match and R2 halt", rd_tx, 32'h0003);
        tick(); rd(4'h6, 1'b0);
        chk("R6 match holds", rd_tx, 32'h0003);
        wr_status(16'hFFFB); rd(4'h6, 1'b0);
        chk("R7 bits 0 1 ignore writes", rd_tx, 32'h0003);
        last_idx = 3'd5;
        tick(); rd(4'h6, 1'b0);
        chk("R6 match drops on new last", rd_tx, 32'h0000);
    endtask

    task automatic t_stop();
        run = 1'b0; eng_idle = 1'b0;
        tick(); rd(4'h6, 1'b0);
        chk("R2 draining not halted", rd_tx, 32'h0000);
        eng_idle = 1'b1;
        tick(); rd(4'h6, 1'b0);
        chk("R2 stop halts", rd_tx, 32'h0001);
        wr_status(16'hFFFE); rd(4'h6, 1'b0);
        chk("R7 upper bits zero", rd_tx, 32'h0001);
    endtask

    task automatic t_rx();
        run = 1'b1; eng_idle = 1'b0; cur_idx = 3'd4; last_idx = 3'd4;
        buf_written = 1'b1;
        tick(); buf_written = 1'b0; rd(4'h6, 1'b0);
        chk("R3 rx sets on write", rd_rx, 32'h0004);
        chk("R3 tx ignores write", rd_tx, 32'h0000);
        chk("R5 rx irq", {31'b0, irq_rx}, 32'h1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_tx_completion();
        t_clear();
        t_set_wins();
        t_position();
        t_readwin();
        t_match_halt();
        t_stop();
        t_rx();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule